// File: doc/BRIEF.md
# Status-Tagged Receive Byte Queue

This block is the storage stage behind a serial packet deframer. Each received byte arrives with a two-bit tag that marks it as the opening byte of a packet, a middle byte, or the closing byte of a good or a bad packet. The block keeps byte and tag together in a 16-entry queue. It shows the tag of the byte at the head before that byte is taken, so the host can learn where a packet ends, and whether it was good, before it pops the byte.

Two end-of-packet interrupts are raised. The write-side interrupt means that the byte written most recently closed a packet. The read-side interrupt means that the byte waiting at the head closes a packet. A host acknowledge pulse clears both. A full queue never overwrites a stored byte. The first byte that finds no room puts the queue into a drop state, and every later byte is discarded until the deframer reports a new opening flag. The packet that was cut short therefore loses its closing tag. The host sees this as an opening tag followed by another opening tag with no closing tag between them.

The read side is a valid/ready stream. `rd_valid` is high whenever the queue holds a byte. The head byte and its tag stay stable until a cycle in which `rd_valid` and `rd_ready` are both high, and that cycle pops the byte. The write side has no back-pressure by design, because the serial line cannot be stalled. `wr_valid` offers a byte in every cycle it is high, and the block either stores that byte or drops it. Reads still work while reception is disabled.

Top module: `pkt_tag_fifo`

## Requirements
- R1: Each stored byte keeps its tag. `rd_data`/`rd_tag` show the oldest byte while `rd_valid` is high and do not change until it is popped by `rd_valid && rd_ready`. Bytes leave in the order they were stored. The tag codes are 2'b01 opening byte, 2'b00 middle byte, 2'b10 closing byte of a good packet and 2'b11 closing byte of a bad packet.
- R2: `level` counts the stored bytes, from 0 to 16. `empty` is high exactly when `level` is 0, `full` is high exactly when `level` is 16, and `rd_valid` equals `!empty`.
- R3: A write to a full queue with no pop in the same cycle is discarded. The stored contents stay unchanged, and `drop_active` is high from the next cycle.
- R4: While `drop_active` is high, every write is discarded, even if space has been freed. An `open_flag` pulse ends the drop state. A write in the same cycle as that pulse is stored if there is room.
- R5: After a drop, the truncated packet's stored bytes are followed directly by the next packet's opening byte, with no closing tag between them.
- R6: `eop_wr_irq` goes high the cycle after a stored byte tagged 2'b10 or 2'b11 and goes low after a stored byte with any other tag. `irq_ack` clears it, unless a closing byte is stored in the same cycle.
- R7: `eop_rd_irq` is high while the head byte carries tag 2'b10 or 2'b11, unless `irq_ack` has been pulsed since that byte became the head.
- R8: A write and a pop in the same cycle on a full queue both take effect. `level` stays at 16 and no drop starts.
- R9: `flush` empties the queue, ends the drop state and clears both interrupts in the next cycle. It overrides a write or a pop in the same cycle.
- R10: While `rx_en` is low, writes are ignored and start no drop. Reads keep working.
- R11: After reset the queue is empty, `level` is 0, and `drop_active` and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; gates writes only |
| flush | input | 1 | Synchronous clear of the queue and the drop state |
| open_flag | input | 1 | Pulse: deframer has seen an opening flag |
| wr_valid | input | 1 | Byte offered from the deframer |
| wr_data | input | 8 | Received byte |
| wr_tag | input | 2 | Packet tag of the offered byte |
| rd_valid | output | 1 | Head byte available |
| rd_ready | input | 1 | Host takes the head byte |
| rd_data | output | 8 | Head byte |
| rd_tag | output | 2 | Tag of the head byte |
| full | output | 1 | All 16 entries in use |
| empty | output | 1 | No entries in use |
| level | output | 5 | Number of stored bytes |
| drop_active | output | 1 | Overflow drop state |
| irq_ack | input | 1 | Pulse clearing both interrupts |
| eop_wr_irq | output | 1 | Last stored byte closed a packet |
| eop_rd_irq | output | 1 | Head byte closes a packet |

## Verification
Two functions can fall in the same cycle. A write can land on a full queue while the host pops, and an acknowledge can arrive while a closing byte is written into an empty queue. The bench fills the queue to 16 and then drives `wr_valid` and `rd_ready` together. It expects `level` to stay at 16, `drop_active` to stay low and the head to advance. A closing byte written into an empty queue in the acknowledge cycle must leave both interrupts high, because the new write and the new head win over the acknowledge.

// File: rtl/pkt_tag_pkg.sv
package pkt_tag_pkg;

  localparam int BYTE_W = 8;
  localparam int TAG_W  = 2;

  // Tag codes carried next to every byte; bit 1 set marks a closing byte.
  typedef enum logic [TAG_W-1:0] {
    TAG_MID     = 2'b00,
    TAG_FIRST   = 2'b01,
    TAG_END_OK  = 2'b10,
    TAG_END_BAD = 2'b11
  } tag_e;

  typedef struct packed {
    tag_e              tag;
    logic [BYTE_W-1:0] data;
  } entry_t;

endpackage

// File: rtl/ptf_store.sv
module ptf_store
  import pkt_tag_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  entry_t                     wr_entry,
  output entry_t                     head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);

  localparam int  AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int  CW    = $clog2(DEPTH+1);
  localparam bit  POW2  = (DEPTH & (DEPTH - 1)) == 0;

  entry_t         mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [AW-1:0]  wr_nxt, rd_nxt;
  logic [CW-1:0]  cnt_q;

  // Pointer increment: free wrap for power-of-two depths, compare otherwise.
  generate
    if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      unique case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/ptf_admit.sv
module ptf_admit (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic rx_en,
  input  logic open_flag,
  input  logic wr_valid,
  input  logic full,
  input  logic pop,
  output logic push,
  output logic drop_active
);

  logic drop_q;
  logic lock_now;
  logic attempt;
  logic has_room;
  logic overflow;

  // An opening flag lifts the lock for the write in the same cycle.
  assign lock_now = drop_q && !open_flag;
  assign has_room = !full || pop;
  assign attempt  = wr_valid && rx_en && !flush && !lock_now;
  assign push     = attempt && has_room;
  assign overflow = attempt && !has_room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         drop_q <= 1'b0;
    else if (flush)     drop_q <= 1'b0;
    else if (overflow)  drop_q <= 1'b1;
    else if (open_flag) drop_q <= 1'b0;
  end

  assign drop_active = drop_q;

endmodule

// File: rtl/ptf_irq.sv
module ptf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push,
  input  logic pop,
  input  logic was_empty,
  input  logic wr_is_end,
  input  logic head_is_end,
  input  logic ack,
  output logic eop_wr,
  output logic eop_rd
);

  logic wr_q;
  logic rd_masked_q;
  logic head_moves;

  assign head_moves = pop || (push && was_empty);

  // Write side: tracks the tag of the latest stored byte; ack loses to a store.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_q <= 1'b0;
    else if (flush) wr_q <= 1'b0;
    else if (push)  wr_q <= wr_is_end;
    else if (ack)   wr_q <= 1'b0;
  end

  // Read side: ack masks the current head until a new byte takes its place.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_masked_q <= 1'b0;
    else if (flush)      rd_masked_q <= 1'b0;
    else if (head_moves) rd_masked_q <= 1'b0;
    else if (ack)        rd_masked_q <= 1'b1;
  end

  assign eop_wr = wr_q;
  assign eop_rd = !was_empty && head_is_end && !rd_masked_q;

endmodule

// File: rtl/pkt_tag_fifo.sv
module pkt_tag_fifo
  import pkt_tag_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_en,
  input  logic                       flush,
  input  logic                       open_flag,
  input  logic                       wr_valid,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [TAG_W-1:0]           wr_tag,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [TAG_W-1:0]           rd_tag,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       drop_active,
  input  logic                       irq_ack,
  output logic                       eop_wr_irq,
  output logic                       eop_rd_irq
);

  entry_t in_entry;
  entry_t head;
  logic   push;
  logic   pop;
  logic   in_end;
  logic   head_end;

  assign in_entry.tag  = tag_e'(wr_tag);
  assign in_entry.data = wr_data;
  assign in_end   = (in_entry.tag == TAG_END_OK) || (in_entry.tag == TAG_END_BAD);
  assign head_end = (head.tag == TAG_END_OK) || (head.tag == TAG_END_BAD);

  assign pop = rd_ready && !empty && !flush;

  ptf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push     (push),
    .pop      (pop),
    .wr_entry (in_entry),
    .head     (head),
    .count    (level),
    .full     (full),
    .empty    (empty)
  );

  ptf_admit u_admit (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .rx_en       (rx_en),
    .open_flag   (open_flag),
    .wr_valid    (wr_valid),
    .full        (full),
    .pop         (pop),
    .push        (push),
    .drop_active (drop_active)
  );

  ptf_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .push        (push),
    .pop         (pop),
    .was_empty   (empty),
    .wr_is_end   (in_end),
    .head_is_end (head_end),
    .ack         (irq_ack),
    .eop_wr      (eop_wr_irq),
    .eop_rd      (eop_rd_irq)
  );

  assign rd_valid = !empty;
  assign rd_data  = head.data;
  assign rd_tag   = head.tag;

endmodule

// File: rtl/ptf_chk.sv
module ptf_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en,
  input logic                       flush,
  input logic                       open_flag,
  input logic                       wr_valid,
  input logic [1:0]                 wr_tag,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic [7:0]                 rd_data,
  input logic [1:0]                 rd_tag,
  input logic                       full,
  input logic                       empty,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       drop_active,
  input logic                       irq_ack,
  input logic                       eop_wr_irq,
  input logic                       eop_rd_irq
);

  localparam int LW = $clog2(DEPTH+1);

  logic wr_closing;
  logic head_closing;
  assign wr_closing   = (wr_tag == 2'b10) || (wr_tag == 2'b11);
  assign head_closing = (rd_tag == 2'b10) || (rd_tag == 2'b11);

  p_head_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !flush |=> rd_valid && $stable(rd_data) && $stable(rd_tag));

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_idle_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !wr_valid && !flush |=> empty);

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_valid && rx_en && !rd_ready && !flush |=> drop_active && full);

  p_locked_no_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_active && !open_flag && !flush |=> level <= $past(level));

  p_wr_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && rx_en && !full && !drop_active && !flush && wr_closing |=> eop_wr_irq);

  p_rd_irq_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eop_rd_irq |-> rd_valid && head_closing);

  p_rd_irq_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && rd_valid && !rd_ready && !wr_valid && !flush |=> !eop_rd_irq);

  p_pass_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full && rd_ready && wr_valid && rx_en && !drop_active && !flush |=> full && !drop_active);

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !drop_active && !eop_wr_irq && !eop_rd_irq);

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !drop_active && !flush |=> !drop_active && level <= $past(level));

endmodule

bind pkt_tag_fifo ptf_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_pkt_tag_fifo.sv
module sim_pkt_tag_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       flush = 1'b0;
  logic       open_flag = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wr_tag = '0;
  logic       rd_ready = 1'b0;
  logic       irq_ack = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [1:0] rd_tag;
  logic       full, empty, drop_active, eop_wr_irq, eop_rd_irq;
  logic [4:0] level;

  int  n_run = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  pkt_tag_fifo #(.DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush), .open_flag(open_flag),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_tag(rd_tag),
    .full(full), .empty(empty), .level(level), .drop_active(drop_active),
    .irq_ack(irq_ack), .eop_wr_irq(eop_wr_irq), .eop_rd_irq(eop_rd_irq)
  );

  typedef struct packed {
    logic       wv;
    logic [1:0] tg;
    logic [7:0] d;
    logic       rr;
    logic       of;
    logic       fl;
    logic       ack;
    logic [4:0] lvl;
    logic       rv;
    logic [7:0] hd;
    logic [1:0] ht;
    logic       wi;
    logic       ri;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'b01, 8'hA1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 1'b1, 8'hA1, 2'b01, 1'b0, 1'b0},
    '{1'b1, 2'b00, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2, 1'b1, 8'hA1, 2'b01, 1'b0, 1'b0},
    '{1'b1, 2'b10, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 1'b1, 8'hA1, 2'b01, 1'b1, 1'b0},
    '{1'b0, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 1'b1, 8'hA1, 2'b01, 1'b0, 1'b0},
    '{1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd2, 1'b1, 8'h22, 2'b00, 1'b0, 1'b0},
    '{1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1, 1'b1, 8'h33, 2'b10, 1'b0, 1'b1},
    '{1'b0, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1, 1'b1, 8'h33, 2'b10, 1'b0, 1'b0},
    '{1'b1, 2'b01, 8'h44, 1'b1, 1'b1, 1'b0, 1'b0, 5'd1, 1'b1, 8'h44, 2'b01, 1'b0, 1'b0},
    '{1'b1, 2'b11, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2, 1'b1, 8'h44, 2'b01, 1'b1, 1'b0},
    '{1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1, 1'b1, 8'h55, 2'b11, 1'b1, 1'b1},
    '{1'b1, 2'b01, 8'h66, 1'b0, 1'b1, 1'b0, 1'b1, 5'd2, 1'b1, 8'h55, 2'b11, 1'b0, 1'b0},
    '{1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1, 1'b1, 8'h66, 2'b01, 1'b0, 1'b0},
    '{1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0},
    '{1'b0, 2'b00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0},
    '{1'b1, 2'b10, 8'h77, 1'b0, 1'b1, 1'b0, 1'b1, 5'd1, 1'b1, 8'h77, 2'b10, 1'b1, 1'b1},
    '{1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 8'h00, 2'b00, 1'b1, 1'b0},
    '{1'b0, 2'b00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Apply one cycle of stimulus; returns at the next falling edge for sampling.
  task automatic tick(input logic wv, input logic [1:0] tg, input logic [7:0] d,
                      input logic rr, input logic of, input logic fl, input logic ack);
    wr_valid = wv; wr_tag = tg; wr_data = d;
    rd_ready = rr; open_flag = of; flush = fl; irq_ack = ack;
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0; open_flag = 1'b0; flush = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "empty", int'(empty), 1);
    check("R11", "level", int'(level), 0);
    check("R11", "rd_valid", int'(rd_valid), 0);
    check("R11", "drop_active", int'(drop_active), 0);
    check("R11", "eop_wr_irq", int'(eop_wr_irq), 0);
    check("R11", "eop_rd_irq", int'(eop_rd_irq), 0);

    rx_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      tick(TBL[i].wv, TBL[i].tg, TBL[i].d, TBL[i].rr, TBL[i].of, TBL[i].fl, TBL[i].ack);
      check("R2", $sformatf("row %0d level", i), int'(level), int'(TBL[i].lvl));
      check("R2", $sformatf("row %0d rd_valid", i), int'(rd_valid), int'(TBL[i].rv));
      if (TBL[i].rv) begin
        check("R1", $sformatf("row %0d head data", i), int'(rd_data), int'(TBL[i].hd));
        check("R1", $sformatf("row %0d head tag", i), int'(rd_tag), int'(TBL[i].ht));
      end
      check("R6", $sformatf("row %0d eop_wr_irq", i), int'(eop_wr_irq), int'(TBL[i].wi));
      check("R7", $sformatf("row %0d eop_rd_irq", i), int'(eop_rd_irq), int'(TBL[i].ri));
    end

    // Fill to 16: opening byte 0x10 then middle bytes 0x11..0x1F.
    tick(1'b1, 2'b01, 8'h10, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 1; k < 16; k++) tick(1'b1, 2'b00, 8'(8'h10 + k), 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2", "full after 16", int'(full), 1);
    check("R2", "level after 16", int'(level), 16);

    // R8: write and pop together on a full queue.
    tick(1'b1, 2'b00, 8'h20, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8", "level", int'(level), 16);
    check("R8", "drop_active", int'(drop_active), 0);
    check("R8", "head", int'(rd_data), 8'h11);

    // R3: write to full without pop is dropped.
    tick(1'b1, 2'b00, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3", "level", int'(level), 16);
    check("R3", "drop_active", int'(drop_active), 1);
    check("R3", "head", int'(rd_data), 8'h11);

    // R4: freed space is not used until an opening flag.
    tick(1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4", "level after pop", int'(level), 15);
    tick(1'b1, 2'b10, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4", "locked write level", int'(level), 15);
    check("R4", "still dropping", int'(drop_active), 1);
    check("R4", "no wr irq from dropped end", int'(eop_wr_irq), 0);
    tick(1'b1, 2'b01, 8'h30, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R4", "flag write level", int'(level), 16);
    check("R4", "drop released", int'(drop_active), 0);

    // R5: drain; truncated bytes run straight into the next opening byte.
    for (int k = 0; k < 16; k++) begin
      logic [7:0] exp_d;
      logic [1:0] exp_t;
      exp_d = (k < 14) ? 8'(8'h12 + k) : ((k == 14) ? 8'h20 : 8'h30);
      exp_t = (k == 15) ? 2'b01 : 2'b00;
      check("R5", $sformatf("drain %0d data", k), int'(rd_data), int'(exp_d));
      check("R5", $sformatf("drain %0d tag", k), int'(rd_tag), int'(exp_t));
      tick(1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    end
    check("R2", "empty after drain", int'(empty), 1);

    // R9: lock the queue, then flush together with a write.
    for (int k = 0; k < 17; k++) tick(1'b1, 2'b10, 8'(k), 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3", "locked before flush", int'(drop_active), 1);
    tick(1'b1, 2'b01, 8'h99, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R9", "level", int'(level), 0);
    check("R9", "empty", int'(empty), 1);
    check("R9", "drop_active", int'(drop_active), 0);
    check("R9", "eop_wr_irq", int'(eop_wr_irq), 0);

    // R10: disabled receiver ignores writes, reads still drain.
    tick(1'b1, 2'b10, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0);
    rx_en = 1'b0;
    for (int k = 0; k < 20; k++) tick(1'b1, 2'b00, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10", "level while disabled", int'(level), 1);
    check("R10", "no drop while disabled", int'(drop_active), 0);
    check("R10", "head readable", int'(rd_data), 8'h5A);
    tick(1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10", "pop while disabled", int'(level), 0);

    finish_run();
  end

endmodule